// File: doc/BRIEF.md
# Serial Bus Power-Down Sequencer

This block is the clock-master end of a frame-based serial bus. It makes the bit clock and the frame sync from the system clock. It places a 4-bit command/indication (C/I) code at a fixed slot in every frame and reads the code the far end returns in the same slot. It also runs the power-down handshake.

When the far end keeps signalling a deactivate indication, the block answers with the same indication for four frames. It then halts both clocks at the end of the last C/I bit of the fourth answering frame and releases its data output to high impedance. While the bus is halted, the block watches the data input. A filtered low level there counts as a wake request, and the block restarts the clocks from a fresh frame boundary. The far end can then report that it has powered up by sending the power-up code.

Top module: `spd_pdseq`

## Requirements
- R1: A frame has FRAME_BITS bit periods (default 12) of BIT_CLKS system clocks each (default 4). `fsync_o` is high for exactly the first bit period of each frame. `bclk_o` is high for the first half of every bit period.
- R2: The C/I slot covers bits CI_POS to CI_POS+3 of the frame (default bits 4 to 7). The transmitted code goes out MSB first, and its bit 0 is the last bit of the slot. While running normally, the code is `ci_tx_i` as sampled at the start of the frame. Outside the slot, `dout_o` is 1.
- R3: The received code is sampled at the last system clock of each slot bit, MSB first. `ci_rx_o` takes a code only after the same code has arrived in two consecutive frames, and it updates on the clock right after the last slot bit. Reset value is 4'b0000.
- R4: A deactivate indication (DI_CODE, default 4'b1111) seen in only one frame changes nothing. Clocks keep running, and the next frame still carries `ci_tx_i`.
- R5: Once DI_CODE has been accepted in frame N, frames N+1 to N+4 carry DI_CODE in their slot.
- R6: On the system clock right after the last slot bit of frame N+4, `bclk_o`, `fsync_o` and `active_o` go low. Until then they keep running.
- R7: `dout_oe_o` is high while the clocks run and low while they are halted. No bit clock or frame sync appears while it is low.
- R8: While halted, `din_i` goes through a 2-stage synchronizer and must read low on 2 consecutive system clocks. The clocks then restart, with `active_o` high on the 4th clock after `din_i` falls. A low pulse lasting one system clock is ignored.
- R9: A restart begins a new frame, with `fsync_o` and `bclk_o` high on its first clock. Receive history from before the halt is discarded, so a single DI_CODE frame right after a restart does not start a power-down.
- R10: `peer_up_o` is set when the power-up code (PU_CODE, default 4'b0111) is accepted while running, and is cleared when the clocks halt.
- R11: After reset the clocks run, `dout_oe_o` and `active_o` are 1, and `ci_rx_o` and `peer_up_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ci_tx_i | input | CI_W | Code to send in normal operation |
| din_i | input | 1 | Serial data from the far end; also the wake line |
| bclk_o | output | 1 | Bus bit clock |
| fsync_o | output | 1 | Frame sync |
| dout_o | output | 1 | Serial data towards the far end |
| dout_oe_o | output | 1 | Output enable for dout_o (low means high impedance) |
| ci_rx_o | output | CI_W | Last code accepted from the far end |
| active_o | output | 1 | Bus clocks running |
| peer_up_o | output | 1 | Far end has reported power-up |

## Verification
The assertions assume a well-behaved far end. While the clocks are halted, `din_i` is high except for a deliberate wake request. While the bus runs, `din_i` carries a code that is not DI_CODE, so an idle-high line is never misread as a power-down request. The bench keeps to this. It holds `din_i` low (code 0000) between driven frames while running and high while halted. It drives only DI_CODE in the four answering frames, so the line is already high when the clocks stop. Every slot bit is changed on a falling system-clock edge one full bit ahead of the sampling clock.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DEACT = 2'd1,
      ST_IDLE  = 2'd2
   } spd_state_t;

endpackage

// File: rtl/spd_timing.sv
// Bit and frame counters; derives bit clock, frame sync and slot strobes.
module spd_timing #(
   parameter int BIT_CLKS   = 4,
   parameter int FRAME_BITS = 12,
   parameter int CI_POS     = 4,
   parameter int CI_W       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic bclk_o,
   output logic fsync_o,
   output logic in_ci_o,
   output logic bit_end_o,
   output logic ci_end_o,
   output logic frame_start_o
);
   localparam int PH_W    = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
   localparam int BI_W    = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam int HALF    = BIT_CLKS / 2;
   localparam int CI_LAST = CI_POS + CI_W - 1;

   logic [PH_W-1:0] phase_q;
   logic [BI_W-1:0] bit_q;
   logic            ph_wrap;
   logic            bit_wrap;

   assign ph_wrap  = (phase_q == PH_W'(BIT_CLKS - 1));
   assign bit_wrap = (bit_q == BI_W'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         bit_q   <= '0;
      end else if (!run_i) begin
         phase_q <= '0;
         bit_q   <= '0;
      end else if (ph_wrap) begin
         phase_q <= '0;
         bit_q   <= bit_wrap ? '0 : bit_q + 1'b1;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   always_comb begin
      bclk_o        = run_i && (phase_q < PH_W'(HALF));
      fsync_o       = run_i && (bit_q == '0);
      in_ci_o       = run_i && (bit_q >= BI_W'(CI_POS)) && (bit_q <= BI_W'(CI_LAST));
      bit_end_o     = run_i && ph_wrap;
      ci_end_o      = bit_end_o && (bit_q == BI_W'(CI_LAST));
      frame_start_o = run_i && (phase_q == '0) && (bit_q == '0);
   end

endmodule

// File: rtl/spd_ci_rx.sv
// Slot receiver with two-frame persistence check.
module spd_ci_rx #(
   parameter int CI_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            smp_i,
   input  logic            last_i,
   input  logic            din_i,
   output logic [CI_W-1:0] word_o,
   output logic            cfm_o,
   output logic [CI_W-1:0] code_o
);
   logic [CI_W-2:0] sh_q;
   logic [CI_W-1:0] prev_q;
   logic            prev_vld_q;

   assign word_o = {sh_q, din_i};
   assign cfm_o  = last_i && prev_vld_q && (word_o == prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
         code_o     <= '0;
      end else if (clear_i) begin
         sh_q       <= '0;
         prev_vld_q <= 1'b0;
      end else begin
         if (smp_i) sh_q <= word_o[CI_W-2:0];
         if (last_i) begin
            prev_q     <= word_o;
            prev_vld_q <= 1'b1;
         end
         if (cfm_o) code_o <= word_o;
      end
   end

endmodule

// File: rtl/spd_treq.sv
// Wake-request detector: multi-stage synchronizer plus low-level filter.
module spd_treq #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_MIN     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic din_i,
   output logic sync_o,
   output logic req_o
);
   localparam int CW = (LOW_MIN > 1) ? $clog2(LOW_MIN) : 1;

   logic [SYNC_STAGES-1:0] stg_q;
   logic [CW-1:0]          cnt_q;

   generate
      for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= 1'b1;
               else        stg_q[gi] <= din_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= 1'b1;
               else        stg_q[gi] <= stg_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_o = stg_q[SYNC_STAGES-1];
   assign req_o  = arm_i && !sync_o && (cnt_q == CW'(LOW_MIN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!arm_i || sync_o)     cnt_q <= '0;
      else if (cnt_q != CW'(LOW_MIN - 1)) cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/spd_fsm.sv
// Power-down handshake controller.
module spd_fsm
   import spd_pkg::*;
#(
   parameter int              CI_W        = 4,
   parameter int              STOP_FRAMES = 4,
   parameter logic [CI_W-1:0] DI_CODE     = 4'b1111,
   parameter logic [CI_W-1:0] PU_CODE     = 4'b0111
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfm_i,
   input  logic [CI_W-1:0] word_i,
   input  logic            frame_start_i,
   input  logic            ci_end_i,
   input  logic            treq_i,
   output logic            run_o,
   output logic            idle_o,
   output logic            sel_di_o,
   output logic            peer_up_o
);
   localparam int FC_W = $clog2(STOP_FRAMES + 1);

   spd_state_t      st_q;
   logic [FC_W-1:0] fcnt_q;

   assign idle_o   = (st_q == ST_IDLE);
   assign sel_di_o = (st_q == ST_DEACT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RUN;
         fcnt_q    <= '0;
         run_o     <= 1'b1;
         peer_up_o <= 1'b0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (cfm_i && word_i == DI_CODE) begin
                  st_q   <= ST_DEACT;
                  fcnt_q <= '0;
               end else if (cfm_i && word_i == PU_CODE) begin
                  peer_up_o <= 1'b1;
               end
            end
            ST_DEACT: begin
               if (frame_start_i) fcnt_q <= fcnt_q + 1'b1;
               if (ci_end_i && fcnt_q == FC_W'(STOP_FRAMES)) begin
                  st_q      <= ST_IDLE;
                  run_o     <= 1'b0;
                  peer_up_o <= 1'b0;
               end
            end
            ST_IDLE: begin
               if (treq_i) begin
                  st_q  <= ST_RUN;
                  run_o <= 1'b1;
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

endmodule

// File: rtl/spd_pdseq.sv
// Top: clock master with C/I slotting, power-down handshake and wake detection.
module spd_pdseq #(
   parameter int              BIT_CLKS    = 4,
   parameter int              FRAME_BITS  = 12,
   parameter int              CI_POS      = 4,
   parameter int              CI_W        = 4,
   parameter int              STOP_FRAMES = 4,
   parameter int              SYNC_STAGES = 2,
   parameter int              LOW_MIN     = 2,
   parameter logic [CI_W-1:0] DI_CODE     = 4'b1111,
   parameter logic [CI_W-1:0] PU_CODE     = 4'b0111
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CI_W-1:0] ci_tx_i,
   input  logic            din_i,
   output logic            bclk_o,
   output logic            fsync_o,
   output logic            dout_o,
   output logic            dout_oe_o,
   output logic [CI_W-1:0] ci_rx_o,
   output logic            active_o,
   output logic            peer_up_o
);
   generate
      if (BIT_CLKS < 2 || (BIT_CLKS % 2) != 0) begin : g_bad_bitclks
         $error("BIT_CLKS must be even and at least 2");
      end
      if (CI_W < 2) begin : g_bad_ciw
         $error("CI_W must be at least 2");
      end
      if (CI_POS < 1 || CI_POS + CI_W > FRAME_BITS) begin : g_bad_slot
         $error("C/I slot must lie inside the frame and after the sync bit");
      end
      if (STOP_FRAMES < 1) begin : g_bad_stop
         $error("STOP_FRAMES must be at least 1");
      end
      if (SYNC_STAGES < 2 || LOW_MIN < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2 and LOW_MIN at least 1");
      end
   endgenerate

   logic            run;
   logic            idle;
   logic            sel_di;
   logic            in_ci;
   logic            bit_end;
   logic            ci_end;
   logic            frame_start;
   logic            cfm;
   logic [CI_W-1:0] rx_word;
   logic            treq;
   logic            din_sync;
   logic [CI_W-1:0] tx_sh;

   spd_timing #(
      .BIT_CLKS  (BIT_CLKS),
      .FRAME_BITS(FRAME_BITS),
      .CI_POS    (CI_POS),
      .CI_W      (CI_W)
   ) u_tim (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .bclk_o       (bclk_o),
      .fsync_o      (fsync_o),
      .in_ci_o      (in_ci),
      .bit_end_o    (bit_end),
      .ci_end_o     (ci_end),
      .frame_start_o(frame_start)
   );

   spd_ci_rx #(.CI_W(CI_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(idle),
      .smp_i  (bit_end && in_ci),
      .last_i (ci_end),
      .din_i  (din_i),
      .word_o (rx_word),
      .cfm_o  (cfm),
      .code_o (ci_rx_o)
   );

   spd_treq #(
      .SYNC_STAGES(SYNC_STAGES),
      .LOW_MIN    (LOW_MIN)
   ) u_treq (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (idle),
      .din_i (din_i),
      .sync_o(din_sync),
      .req_o (treq)
   );

   spd_fsm #(
      .CI_W       (CI_W),
      .STOP_FRAMES(STOP_FRAMES),
      .DI_CODE    (DI_CODE),
      .PU_CODE    (PU_CODE)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfm_i        (cfm),
      .word_i       (rx_word),
      .frame_start_i(frame_start),
      .ci_end_i     (ci_end),
      .treq_i       (treq),
      .run_o        (run),
      .idle_o       (idle),
      .sel_di_o     (sel_di),
      .peer_up_o    (peer_up_o)
   );

   // Transmit code is latched at the frame boundary and shifted out MSB first.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tx_sh <= '1;
      else if (frame_start)       tx_sh <= sel_di ? DI_CODE : ci_tx_i;
      else if (bit_end && in_ci)  tx_sh <= {tx_sh[CI_W-2:0], 1'b1};
   end

   assign dout_o    = in_ci ? tx_sh[CI_W-1] : 1'b1;
   assign dout_oe_o = run;
   assign active_o  = run;

endmodule

// File: rtl/spd_pdseq_chk.sv
// Property checker bound into spd_pdseq.
module spd_pdseq_chk #(
   parameter int              CI_W    = 4,
   parameter logic [CI_W-1:0] PU_CODE = 4'b0111
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bclk_o,
   input logic            fsync_o,
   input logic            dout_oe_o,
   input logic            active_o,
   input logic [CI_W-1:0] ci_rx_o,
   input logic            peer_up_o,
   input logic            ci_end,
   input logic            din_sync
);

   p_fs_opens_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_o) |-> bclk_o);

   p_rx_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ci_rx_o) |-> $past(ci_end));

   p_halt_at_slot_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> $past(ci_end));

   p_quiet_when_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe_o |-> (!bclk_o && !fsync_o));

   p_wake_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> !$past(din_sync));

   p_fresh_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> (fsync_o && bclk_o));

   p_peer_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(peer_up_o) |-> (ci_rx_o == PU_CODE));

endmodule

bind spd_pdseq spd_pdseq_chk #(
   .CI_W   (CI_W),
   .PU_CODE(PU_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bclk_o   (bclk_o),
   .fsync_o  (fsync_o),
   .dout_oe_o(dout_oe_o),
   .active_o (active_o),
   .ci_rx_o  (ci_rx_o),
   .peer_up_o(peer_up_o),
   .ci_end   (ci_end),
   .din_sync (din_sync)
);

// File: tb/sim_spd_pdseq.sv
`timescale 1ns/1ps
module sim_spd_pdseq;
   localparam int BC = 4;
   localparam int FB = 12;
   localparam int CP = 4;
   localparam logic [3:0] DI = 4'b1111;
   localparam logic [3:0] PU = 4'b0111;
   localparam logic [3:0] TXC = 4'b0011;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ci_tx = TXC;
   logic       din = 1'b0;
   logic       bclk, fsync, dout, dout_oe, active, peer_up;
   logic [3:0] ci_rx;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   spd_pdseq #(
      .BIT_CLKS(BC), .FRAME_BITS(FB), .CI_POS(CP), .CI_W(4),
      .STOP_FRAMES(4), .SYNC_STAGES(2), .LOW_MIN(2),
      .DI_CODE(DI), .PU_CODE(PU)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ci_tx_i(ci_tx), .din_i(din),
      .bclk_o(bclk), .fsync_o(fsync), .dout_o(dout), .dout_oe_o(dout_oe),
      .ci_rx_o(ci_rx), .active_o(active), .peer_up_o(peer_up)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_fs();
      logic p;
      p = fsync;
      @(negedge clk);
      while (!(fsync && !p)) begin
         p = fsync;
         @(negedge clk);
      end
   endtask

   // Drives one received code in a frame slot and captures the transmitted one.
   task automatic xfer(input logic [3:0] rxc, input bit nowait,
                       output logic [3:0] txc, output logic act_pre, output logic act_post);
      if (!nowait) wait_fs();
      repeat (CP*BC) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         din = rxc[3-k];
         txc[3-k] = dout;
         repeat (BC-1) @(negedge clk);
         if (k == 3) act_pre = active;
         @(negedge clk);
      end
      act_post = active;
      din = active ? 1'b0 : 1'b1;
   endtask

   task automatic t_reset();
      chk("R11 active", active, 1);
      chk("R11 oe", dout_oe, 1);
      chk("R11 ci_rx", ci_rx, 0);
      chk("R11 peer_up", peer_up, 0);
   endtask

   task automatic t_frame_timing();
      int hi, per;
      logic b0, b2, d0, seen_low;
      wait_fs();
      b0 = bclk; d0 = dout; b2 = 1'b0;
      hi = 1; per = 0; seen_low = 1'b0;
      for (int i = 1; i < 100; i++) begin
         @(negedge clk);
         if (i == 2) b2 = bclk;
         if (!fsync) seen_low = 1'b1;
         if (fsync && !seen_low) hi++;
         if (fsync && seen_low) begin per = i; break; end
      end
      chk("R1 fsync width", hi, BC);
      chk("R1 frame period", per, FB*BC);
      chk("R1 bclk high first half", b0, 1);
      chk("R1 bclk low second half", b2, 0);
      chk("R2 idle level outside slot", d0, 1);
   endtask

   task automatic t_rx_persist();
      logic [3:0] t; logic a, b;
      xfer(4'b1010, 0, t, a, b);
      chk("R2 tx code MSB first", t, TXC);
      chk("R3 single frame not taken", ci_rx, 4'b0000);
      xfer(4'b0101, 0, t, a, b);
      chk("R3 first of pair not taken", ci_rx, 4'b0000);
      xfer(4'b0101, 0, t, a, b);
      chk("R3 pair accepted", ci_rx, 4'b0101);
      xfer(4'b1010, 0, t, a, b);
      xfer(4'b0000, 0, t, a, b);
      chk("R3 split pair ignored", ci_rx, 4'b0101);
   endtask

   task automatic t_single_di();
      logic [3:0] t; logic a, b;
      xfer(DI, 0, t, a, b);
      chk("R4 running after one DI", b, 1);
      xfer(4'b0000, 0, t, a, b);
      chk("R4 still normal code", t, TXC);
      chk("R4 still running", b, 1);
   endtask

   task automatic t_deact(input string tag);
      logic [3:0] t; logic a, b;
      xfer(DI, 0, t, a, b);
      xfer(DI, 0, t, a, b);
      chk({"R4 running at accept ", tag}, b, 1);
      for (int f = 1; f <= 4; f++) begin
         xfer(DI, 0, t, a, b);
         chk({"R5 answer code ", tag}, t, DI);
         chk({"R6 running to slot end ", tag}, a, 1);
         if (f < 4) chk({"R6 running between ", tag}, b, 1);
      end
      chk({"R6 halted ", tag}, b, 0);
      chk({"R6 bclk low ", tag}, bclk, 0);
      chk({"R7 oe low ", tag}, dout_oe, 0);
      chk({"R10 peer_up cleared ", tag}, peer_up, 0);
      begin
         int noise = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk || fsync || dout_oe) noise++;
         end
         chk({"R7 quiet while halted ", tag}, noise, 0);
      end
   endtask

   task automatic t_glitch();
      din = 1'b0;
      @(negedge clk);
      din = 1'b1;
      repeat (10) @(negedge clk);
      chk("R8 glitch ignored", active, 0);
   endtask

   task automatic t_wake();
      logic [3:0] t; logic a, b;
      din = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 not yet awake", active, 0);
      @(negedge clk);
      chk("R8 awake on 4th clock", active, 1);
      chk("R9 fsync opens", fsync, 1);
      chk("R9 bclk opens", bclk, 1);
      chk("R7 oe back", dout_oe, 1);
      xfer(DI, 1, t, a, b);
      xfer(PU, 0, t, a, b);
      chk("R9 no stale DI pair", t, TXC);
      chk("R9 still running", b, 1);
      xfer(PU, 0, t, a, b);
      chk("R10 peer_up set", peer_up, 1);
      chk("R10 code shown", ci_rx, PU);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame_timing();
      t_rx_persist();
      t_single_di();
      t_deact("first");
      t_glitch();
      t_wake();
      t_deact("second");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule